// File: doc/BRIEF.md
# Down-Counting Interval Timer Bank

A bank of identical 32-bit interval timers behind one shared register decoder. Each timer counts down from a programmed load value. It counts at a rate set by a per-timer prescaler, which divides the shared tick input by at least two. When the timer passes through zero it emits a single-cycle interrupt pulse. In periodic mode it reloads and keeps going. In one-shot mode it parks at zero until software restarts it.

Software brings a timer up in three writes. The first sets only the clock enable. The second writes the load value. The third sets clock enable, start and, for periodic operation, auto-reload. A periodic timer loaded with all ones never reaches its reload point in practice, so its count runs freely. The bitwise inverse of that count then serves as a monotonic timestamp.

Top module: `interval_timer`

## Requirements
- R1: Instance n occupies byte addresses n*0x100 upward. Its control register is at offset 0x0 and is read/write. Its load register is at 0x4; it is write-only and reads as zero. Its count register is at 0x8; it is read-only, and writes to it are ignored. Any other offset reads zero.
- R2: The control word has start at bit 0, auto-reload at bit 1, prescale select at bits 4:2 and clock enable at bit 5. Bits 31:6 read as zero. After reset, control and count read zero and every interrupt output is low.
- R3: The count changes only while clock enable and start are both 1, and only on cycles where tickIn is high.
- R4: The counter steps once per 2^(p+1) qualifying ticks, where p is the prescale select. A select of 0 therefore divides by 2.
- R5: Writing control so that start goes from 0 to 1 copies the load register into the count and clears the prescaler.
- R6: A step taken while the count is zero raises the timer's interrupt output for exactly one clock, in the cycle after that step. With tickIn held high, the first pulse comes (load+1)*2^(p+1) cycles after the start write.
- R7: With auto-reload set, the step at zero reloads the load value, so pulses repeat every (load+1)*2^(p+1) ticks.
- R8: With auto-reload clear, the count stays at zero after the pulse. No further pulse occurs until start rises again.
- R9: Clearing start halts the count and holds its value.
- R10: A periodic timer loaded with 0xFFFFFFFF and read at intervals gives an inverted count that strictly increases.
- R11: Timers are independent. Activity on one instance leaves another's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Shared timer tick enable |
| busAddr | input | ADDR_W | Byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data |
| irqOut | output | NUM_TIMERS | One interrupt pulse line per timer |

## Verification
The bench builds the block with two timers, a 12-bit address and 32-bit data. Two timers bring the 0x100 instance stride and cross-instance isolation within reach. Small load values keep every prescale select up to the largest (divide by 256) inside short windows, so periods can be measured exactly to the cycle. The free-running all-ones case checks the timestamp ordering without waiting for a wrap.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int PRESC_W = 3;

  typedef struct packed {
    logic               run;
    logic               autoReload;
    logic [PRESC_W-1:0] prescale;
    logic               startPulse;
    logic               loadWr;
  } tmrStrobes_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtrl,
  input  logic              wrLoad,
  input  logic [5:0]        wrBits,
  output logic [DATA_W-1:0] ctrlRd,
  output tmrStrobes_t       strb
);
  logic               startBit;
  logic               autoBit;
  logic [PRESC_W-1:0] prescBits;
  logic               clkEnBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit  <= 1'b0;
      autoBit   <= 1'b0;
      prescBits <= '0;
      clkEnBit  <= 1'b0;
    end else if (wrCtrl) begin
      startBit  <= wrBits[0];
      autoBit   <= wrBits[1];
      prescBits <= wrBits[4:2];
      clkEnBit  <= wrBits[5];
    end
  end

  always_comb begin
    ctrlRd      = '0;
    ctrlRd[0]   = startBit;
    ctrlRd[1]   = autoBit;
    ctrlRd[4:2] = prescBits;
    ctrlRd[5]   = clkEnBit;
  end

  always_comb begin
    strb.run        = clkEnBit && startBit;
    strb.autoReload = autoBit;
    strb.prescale   = prescBits;
    strb.startPulse = wrCtrl && wrBits[0] && !startBit;
    strb.loadWr     = wrLoad;
  end

  // R5: a start rising edge leaves start set in the control register
  assert_start_latched_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.startPulse |=> ctrlRd[0]);
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  tmrStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] count,
  output logic              irqOut
);
  localparam int DIV_W = 2 ** PRESC_W;

  logic [DATA_W-1:0] loadReg;
  logic [DIV_W-1:0]  prescCnt;
  logic [DIV_W-1:0]  divLast;
  logic              doneFlag;
  logic              tickOk;
  logic              stepNow;

  always_comb begin
    divLast = ~({DIV_W{1'b1}} << (int'(strb.prescale) + 1));
    tickOk  = strb.run && tickIn && !doneFlag;
    stepNow = tickOk && (prescCnt >= divLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg  <= '0;
      prescCnt <= '0;
      count    <= '0;
      doneFlag <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      irqOut <= 1'b0;
      if (strb.loadWr) loadReg <= wrData;
      if (strb.startPulse) begin
        count    <= loadReg;
        prescCnt <= '0;
        doneFlag <= 1'b0;
      end else if (stepNow) begin
        prescCnt <= '0;
        if (count == '0) begin
          irqOut <= 1'b1;
          if (strb.autoReload) count <= loadReg;
          else doneFlag <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end else if (tickOk) begin
        prescCnt <= prescCnt + 1'b1;
      end
    end
  end

  // R6: interrupt is a single-cycle pulse
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);
  // R9: no run, no start edge -> count holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.startPulse) |=> $stable(count));
  // R4: a nonzero count moves by at most one step
  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.startPulse && count != '0) |=>
      (count == $past(count) || count == $past(count) - 1'b1));
  // R8: one-shot parks at zero
  assert_park_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.autoReload && !strb.startPulse && count == '0) |=> count == '0);
  // R8: expired one-shot stays quiet
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !strb.startPulse) |=> !irqOut);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickIn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic [NUM_TIMERS-1:0] irqOut
);
  localparam int STRIDE_SH = 8;
  localparam int SEL_W     = ADDR_W - STRIDE_SH;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_LOAD  = 8'h04;
  localparam logic [7:0] OFF_COUNT = 8'h08;

  logic [SEL_W-1:0]  instSel;
  logic [7:0]        regOff;
  logic [DATA_W-1:0] ctrlRd  [NUM_TIMERS];
  logic [DATA_W-1:0] countRd [NUM_TIMERS];

  assign instSel = busAddr[ADDR_W-1:STRIDE_SH];
  assign regOff  = busAddr[7:0];

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : gTimer
    logic        hit;
    tmrStrobes_t strb;
    assign hit = (instSel == SEL_W'(i));

    timer_ctrl #(.DATA_W(DATA_W)) ctrl_i (
      .clk    (clk),
      .rstN   (rstN),
      .wrCtrl (busWrEn && hit && regOff == OFF_CTRL),
      .wrLoad (busWrEn && hit && regOff == OFF_LOAD),
      .wrBits (busWrData[5:0]),
      .ctrlRd (ctrlRd[i]),
      .strb   (strb)
    );

    timer_datapath #(.DATA_W(DATA_W)) dp_i (
      .clk    (clk),
      .rstN   (rstN),
      .tickIn (tickIn),
      .strb   (strb),
      .wrData (busWrData),
      .count  (countRd[i]),
      .irqOut (irqOut[i])
    );
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (instSel == SEL_W'(i)) begin
        if (regOff == OFF_CTRL)       busRdData = ctrlRd[i];
        else if (regOff == OFF_COUNT) busRdData = countRd[i];
      end
    end
  end
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam int NT = 2;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickIn = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic [NT-1:0] irqOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  interval_timer #(.NUM_TIMERS(NT), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  typedef struct packed {
    logic [0:0]  inst;
    logic [31:0] load;
    logic [2:0]  presc;
    logic        auto;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 32'd3, 3'd0, 1'b1},
    '{1'b1, 32'd0, 3'd0, 1'b1},
    '{1'b0, 32'd5, 3'd1, 1'b0},
    '{1'b1, 32'd2, 3'd2, 1'b1},
    '{1'b0, 32'd1, 3'd7, 1'b0},
    '{1'b1, 32'd4, 3'd3, 1'b1}
  };

  function automatic logic [31:0] ctl(bit en, logic [2:0] p, bit ar, bit st);
    return {26'd0, en, p, ar, st};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(int inst, logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    busAddr = AW'(inst * 256 + off);
    busWrData = d;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(int inst, logic [7:0] off, output logic [31:0] d);
    busAddr = AW'(inst * 256 + off);
    #1 d = busRdData;
  endtask

  task automatic waitCycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // cycles from now until irq of inst seen, limit bounded
  task automatic measureIrq(int inst, int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (irqOut[inst] && n < 0) n = k;
      if (n >= 0) break;
    end
  endtask

  initial begin
    #400us;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    int n, per, other;
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R2: reset state
    busRead(0, 8'h00, rd);  check(rd == 0, "R2 ctrl reset", rd, 0);
    busRead(1, 8'h08, rd);  check(rd == 0, "R2 count reset", rd, 0);
    check(irqOut == 0, "R2 irq reset", 32'(irqOut), 0);

    // vector table: R4 R5 R6 R7 R8
    foreach (VECS[v]) begin
      per = int'(VECS[v].load + 1) << (int'(VECS[v].presc) + 1);
      busWrite(VECS[v].inst, 8'h00, ctl(1, 0, 0, 0));
      busWrite(VECS[v].inst, 8'h04, VECS[v].load);
      busWrite(VECS[v].inst, 8'h00, ctl(1, VECS[v].presc, VECS[v].auto, 1));
      measureIrq(VECS[v].inst, per + 8, n);
      check(n == per, "R6 first period", n, per);
      @(negedge clk);
      check(!irqOut[VECS[v].inst], "R6 pulse width", 32'(irqOut), 0);
      if (VECS[v].auto) begin
        measureIrq(VECS[v].inst, per + 8, n);
        check(n == per - 1, "R7 reload period", n + 1, per);
      end else begin
        measureIrq(VECS[v].inst, 2 * per + 8, n);
        check(n < 0, "R8 no second pulse", n, 32'hFFFFFFFF);
        busRead(VECS[v].inst, 8'h08, rd);
        check(rd == 0, "R8 parked at zero", rd, 0);
      end
      busWrite(VECS[v].inst, 8'h00, ctl(1, 0, 0, 0));
    end

    // R2: reserved bits read zero
    busWrite(0, 8'h00, 32'hFFFFFFC0 | ctl(1, 3'd5, 1, 0));
    busRead(0, 8'h00, rd);
    check(rd == 32'h00000036, "R2 layout", rd, 32'h36);

    // R1: load reads zero, count write ignored, unused offset zero
    busWrite(0, 8'h00, ctl(1, 0, 0, 0));
    busWrite(0, 8'h04, 32'd77);
    busRead(0, 8'h04, rd);  check(rd == 0, "R1 load reads zero", rd, 0);
    busRead(0, 8'h08, rd2);
    busWrite(0, 8'h08, 32'h1234);
    busRead(0, 8'h08, rd);  check(rd == rd2, "R1 count write ignored", rd, rd2);
    busRead(0, 8'h0C, rd);  check(rd == 0, "R1 unused offset", rd, 0);

    // R3: start without clock enable loads but does not count
    busWrite(0, 8'h00, ctl(0, 0, 0, 1));
    waitCycles(20);
    busRead(0, 8'h08, rd);  check(rd == 77, "R3 clkEn gate", rd, 77);

    // R3: tickIn low stalls counting
    busWrite(0, 8'h00, ctl(1, 0, 0, 1));
    tickIn = 1'b0;
    waitCycles(20);
    busRead(0, 8'h08, rd);  check(rd == 77, "R3 tick gate", rd, 77);
    tickIn = 1'b1;
    waitCycles(20);
    busRead(0, 8'h08, rd);  check(rd == 67, "R4 divide by 2", rd, 67);

    // R9: clear start holds count; R11: other instance untouched
    busRead(1, 8'h08, rd2);
    busWrite(0, 8'h00, ctl(1, 0, 0, 0));
    busRead(0, 8'h08, rd);
    waitCycles(30);
    busRead(0, 8'h08, other);
    check(32'(other) == rd, "R9 hold", 32'(other), rd);
    busRead(1, 8'h08, rd);
    check(rd == rd2, "R11 isolation", rd, rd2);

    // R5: restart reloads
    busWrite(0, 8'h00, ctl(1, 0, 0, 1));
    busRead(0, 8'h08, rd);  check(rd == 77, "R5 restart reload", rd, 77);

    // R10: free-running timestamp
    busWrite(1, 8'h00, ctl(1, 0, 0, 0));
    busWrite(1, 8'h04, 32'hFFFFFFFF);
    busWrite(1, 8'h00, ctl(1, 0, 1, 1));
    waitCycles(10);
    busRead(1, 8'h08, rd);
    waitCycles(40);
    busRead(1, 8'h08, rd2);
    check(~rd2 > ~rd && ~rd > 0, "R10 monotonic", ~rd2, ~rd);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule